// File: doc/BRIEF.md
# Stop-Mode Clock Gate Controller

This block decides when the processor core clock may be switched off and when it must come back. Software first arms it by setting a stop-enable bit in an 8-bit control register. After that, a stop request from the core removes the core clock enable and returns a one-cycle acknowledge. The peripheral clock enable is never removed, so peripherals can keep running and raise interrupts while the core sleeps.

While the core is stopped, an incoming encoded interrupt level is compared against a programmable 3-bit wake threshold. A level strictly above the threshold restores the core clock, with no lock wait, and the core goes straight on to interrupt processing. Threshold 7 shuts out every interrupt, so only the asynchronous active-low reset can end stop mode. The same reset also clears the control register.

The register is 8 bits wide and sits at byte offset 0x08 on a simple register bus. Bit 7 is the stop enable. Bits 6:4 hold the threshold. Bits 3:0 are reserved.

Top module: `core_stop_gate`

## Requirements
- R1: After reset, the register reads 0x00, coreClkEn and periphClkEn are 1, and stopAck is 0.
- R2: A write with busSel=1, busWr=1 and busAddr=0x08 stores busWdata bits 7:4. A read at 0x08 (busSel=1, busWr=0) returns {enable bit 7, threshold bits 6:4, 4'b0000}. Any other address is not stored and reads as 0x00.
- R3: With bit 7 clear, stopReq has no effect: coreClkEn stays 1 and stopAck stays 0.
- R4: With bit 7 set, stopReq high at a rising edge drops coreClkEn from the next cycle. stopAck is 1 for exactly that one cycle.
- R5: periphClkEn is 1 in every cycle, including during stop.
- R6: For thresholds 0 to 6, a level L on irqLevel wakes the core if and only if L > threshold. coreClkEn returns to 1 after the second rising edge that follows the edge where L was first applied.
- R7: With threshold 7 (bits 6:4 = 3'b111), no interrupt level wakes the core.
- R8: irqLevel = 0 means no interrupt and never wakes the core.
- R9: Asserting rstN low ends stop mode at once, sets coreClkEn to 1 and returns the register to 0x00.
- R10: While stopped, a further stopReq produces no stopAck and does not change coreClkEn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register bus access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset of the access |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Combinational read data |
| stopReq | input | 1 | Stop request from the core |
| irqLevel | input | 3 | Encoded pending interrupt level, 0 = none |
| coreClkEn | output | 1 | Core clock enable |
| periphClkEn | output | 1 | Peripheral clock enable |
| stopAck | output | 1 | One-cycle stop acknowledge |

## Verification
The results are due at different times after a stimulus:
- Register read data is combinational, so it is checked one time step after the address is applied.
- The stop response (coreClkEn low and stopAck high) is due one edge after stopReq is sampled.
- A wake is due two edges after irqLevel changes, because the level is registered before it is compared.

Every check samples 1 ns after a rising edge, with the edge count matched to these latencies. The bench also checks that nothing has woken one edge early. The bench sweeps all 64 pairs of threshold and level. When a pair does not wake the core, the bench ends stop mode with reset and checks the cleared register.

// File: rtl/stopgate_pkg.sv
package stopgate_pkg;
  typedef enum logic {ST_RUN = 1'b0, ST_STOP = 1'b1} gateState_e;

  typedef struct packed {
    logic cfgWr;
    logic cfgRd;
  } cfgStrobe_t;
endpackage

// File: rtl/sg_datapath.sv
module sg_datapath
  import stopgate_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LVL_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strobe,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LVL_W-1:0]  irqLevel,
  output logic              stopEn,
  output logic              wakeOk,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned EN_BIT = DATA_W - 1;
  localparam int unsigned THR_LO = EN_BIT - LVL_W;

  logic             stopEnQ;
  logic [LVL_W-1:0] thrQ;
  logic [LVL_W-1:0] irqQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stopEnQ <= 1'b0;
      thrQ    <= '0;
      irqQ    <= '0;
    end else begin
      irqQ <= irqLevel;
      if (strobe.cfgWr) begin
        stopEnQ <= wdata[EN_BIT];
        thrQ    <= wdata[EN_BIT-1:THR_LO];
      end
    end
  end

  // A strictly greater level wakes; level 0 and the all-ones threshold never do.
  assign wakeOk = (irqQ > thrQ);
  assign stopEn = stopEnQ;
  assign rdata  = strobe.cfgRd ? {stopEnQ, thrQ, {THR_LO{1'b0}}} : '0;
endmodule

// File: rtl/sg_control.sv
module sg_control
  import stopgate_pkg::*;
#(
  parameter int unsigned     ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] CFG_OFFSET = 8'h08
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              stopReq,
  input  logic              stopEn,
  input  logic              wakeOk,
  output cfgStrobe_t        strobe,
  output logic              coreClkEn,
  output logic              stopAck
);
  gateState_e state;
  logic       ackQ;
  logic       hit;

  assign hit          = busSel && (busAddr == CFG_OFFSET);
  assign strobe.cfgWr = hit && busWr;
  assign strobe.cfgRd = hit && !busWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_RUN;
      ackQ  <= 1'b0;
    end else begin
      ackQ <= 1'b0;
      unique case (state)
        ST_RUN: if (stopReq && stopEn) begin
          state <= ST_STOP;
          ackQ  <= 1'b1;
        end
        ST_STOP: if (wakeOk) state <= ST_RUN;
        default: state <= ST_RUN;
      endcase
    end
  end

  assign coreClkEn = (state == ST_RUN);
  assign stopAck   = ackQ;
endmodule

// File: rtl/core_stop_gate.sv
module core_stop_gate
  import stopgate_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 8,
  parameter int unsigned       DATA_W     = 8,
  parameter int unsigned       LVL_W      = 3,
  parameter logic [ADDR_W-1:0] CFG_OFFSET = 8'h08
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              stopReq,
  input  logic [LVL_W-1:0]  irqLevel,
  output logic              coreClkEn,
  output logic              periphClkEn,
  output logic              stopAck
);
  cfgStrobe_t strobe;
  logic       stopEn;
  logic       wakeOk;

  sg_control #(.ADDR_W(ADDR_W), .CFG_OFFSET(CFG_OFFSET)) uCtrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .stopReq(stopReq), .stopEn(stopEn), .wakeOk(wakeOk),
    .strobe(strobe), .coreClkEn(coreClkEn), .stopAck(stopAck)
  );

  sg_datapath #(.DATA_W(DATA_W), .LVL_W(LVL_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wdata(busWdata),
    .irqLevel(irqLevel), .stopEn(stopEn), .wakeOk(wakeOk), .rdata(busRdata)
  );

  // Peripherals stay clocked so they can raise wake interrupts.
  assign periphClkEn = 1'b1;
endmodule

// File: rtl/core_stop_gate_chk.sv
module core_stop_gate_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LVL_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [DATA_W-1:0] busRdata,
  input logic              stopReq,
  input logic              stopEn,
  input logic [LVL_W-1:0]  irqLevel,
  input logic              coreClkEn,
  input logic              stopAck
);
  localparam int unsigned RES_HI = DATA_W - LVL_W - 2;

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    stopAck |=> !stopAck); // R4
  AST_ACK_WITH_GATE: assert property (@(posedge clk) disable iff (!rstN)
    stopAck |-> !coreClkEn); // R4
  AST_STOP_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(coreClkEn) |-> $past(stopReq && stopEn)); // R3
  AST_WAKE_NEEDS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coreClkEn) |-> ($past(irqLevel, 2) != '0)); // R8
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr) |-> (busRdata[RES_HI:0] == '0)); // R2
endmodule

bind core_stop_gate core_stop_gate_chk #(.DATA_W(DATA_W), .LVL_W(LVL_W)) uChk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busRdata(busRdata),
  .stopReq(stopReq), .stopEn(stopEn), .irqLevel(irqLevel),
  .coreClkEn(coreClkEn), .stopAck(stopAck)
);

// File: tb/sim_core_stop_gate.sv
`timescale 1ns/1ps
module sim_core_stop_gate;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0, busWr = 1'b0;
  logic [7:0] busAddr = 8'h00, busWdata = 8'h00;
  logic [7:0] busRdata;
  logic       stopReq = 1'b0;
  logic [2:0] irqLevel = 3'd0;
  logic       coreClkEn, periphClkEn, stopAck;
  int         nChk = 0, nBad = 0;
  bit         done = 1'b0;

  core_stop_gate u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .stopReq(stopReq), .irqLevel(irqLevel),
    .coreClkEn(coreClkEn), .periphClkEn(periphClkEn), .stopAck(stopAck)
  );

  always #2.5 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(logic [7:0] addr, logic [7:0] data);
    busSel = 1'b1; busWr = 1'b1; busAddr = addr; busWdata = data;
    tick();
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic regRead(logic [7:0] addr, output logic [7:0] data);
    busSel = 1'b1; busWr = 1'b0; busAddr = addr;
    #1;
    data = busRdata;
    busSel = 1'b0;
  endtask

  task automatic doReset();
    #1 rstN = 1'b0;
    #1;
    check("R9 clk enable in reset", {7'd0, coreClkEn}, 8'd1);
    tick();
    rstN = 1'b1;
    tick();
  endtask

  task automatic enterStop();
    stopReq = 1'b1;
    tick();
    stopReq = 1'b0;
    check("R4 gate off", {7'd0, coreClkEn}, 8'd0);
    check("R4 ack high", {7'd0, stopAck}, 8'd1);
    tick();
    check("R4 ack single", {7'd0, stopAck}, 8'd0);
    check("R5 periph on", {7'd0, periphClkEn}, 8'd1);
  endtask

  initial begin
    logic [7:0] rd;
    tick(); tick();
    rstN = 1'b1;
    tick();
    regRead(8'h08, rd);
    check("R1 reg reset", rd, 8'h00);
    check("R1 clk en", {7'd0, coreClkEn}, 8'd1);
    check("R1 periph en", {7'd0, periphClkEn}, 8'd1);
    check("R1 ack", {7'd0, stopAck}, 8'd0);

    regWrite(8'h08, 8'hFF);
    regRead(8'h08, rd);
    check("R2 reserved masked", rd, 8'hF0);
    regWrite(8'h08, 8'h00);
    regWrite(8'h09, 8'hFF);
    regRead(8'h08, rd);
    check("R2 other addr not stored", rd, 8'h00);
    regRead(8'h09, rd);
    check("R2 other addr reads zero", rd, 8'h00);
    regWrite(8'h08, 8'hA5);
    regRead(8'h08, rd);
    check("R2 pattern", rd, 8'hA0);

    // R3: stop enable clear; 0xA0 keeps bit 7 set, so clear it first
    regWrite(8'h08, 8'h70);
    stopReq = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R3 clk stays on", {7'd0, coreClkEn}, 8'd1);
      check("R3 no ack", {7'd0, stopAck}, 8'd0);
    end
    stopReq = 1'b0;

    // R10: a repeated request while stopped
    regWrite(8'h08, 8'h80);
    enterStop();
    stopReq = 1'b1;
    tick(); tick();
    stopReq = 1'b0;
    check("R10 no second ack", {7'd0, stopAck}, 8'd0);
    check("R10 still gated", {7'd0, coreClkEn}, 8'd0);
    doReset();

    // R6/R7/R8 sweep over every threshold and level
    for (int thr = 0; thr < 8; thr++) begin
      for (int lvl = 0; lvl < 8; lvl++) begin
        bit wake;
        wake = (lvl != 0) && (thr != 7) && (lvl > thr);
        regWrite(8'h08, {1'b1, 3'(thr), 4'h0});
        enterStop();
        irqLevel = 3'(lvl);
        tick();
        check("R6 no early wake", {7'd0, coreClkEn}, 8'd0);
        tick();
        if (thr == 7)      check("R7 blocked", {7'd0, coreClkEn}, 8'd0);
        else if (lvl == 0) check("R8 level zero", {7'd0, coreClkEn}, 8'd0);
        else               check("R6 wake compare", {7'd0, coreClkEn}, {7'd0, wake});
        irqLevel = 3'd0;
        tick();
        if (!wake) begin
          doReset();
          check("R9 clk back", {7'd0, coreClkEn}, 8'd1);
          regRead(8'h08, rd);
          check("R9 reg cleared", rd, 8'h00);
        end
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule